// File: doc/BRIEF.md
# Four-Lane Serial Flash Command Responder

This block is the target-side command front end of a serial flash device whose bus runs in four-lane mode for every phase. While chip select is low it takes a command byte as two nibbles on four data lines, decodes it, and then either streams a value back four bits per clock, collects write data, or arms a power-state change. It answers an identification read, reads and writes of two volatile configuration bytes, a write of a 16-bit non-volatile configuration word, and deep power-down entry and release. An `array_busy` input stands for an erase or program in progress.

The transaction machine has six states. STANDBY waits for selection. OPCODE holds the first nibble. After the second nibble it goes to RDATA (read output), WDATA (write data collection), ARMED (power command waiting for deselect) or IGNORE (rest of the selection discarded). WDATA moves to IGNORE on a nibble past the expected count. RDATA moves to IGNORE after the last identification nibble. ARMED moves to IGNORE on any further nibble. Every state returns to STANDBY when chip select is high at a rising edge, and that edge also executes a pending write or power command whose count is exact. Two small machines sit beside it. The power machine has the states PWR_ON and PWR_DEEP. The non-volatile write machine has the states NV_IDLE and NV_BUSY. The non-volatile write raises `wip` for `NV_WAIT` clocks and loads the new word when that count ends.

The serial clock is treated as a free-running block clock. Inputs are sampled on its rising edge and read nibbles are launched on its falling edge.

Top module: `qspi_cmd_responder`

## Requirements
- R1: The command byte is taken from `dq_in` on two successive rising `sclk` edges with `cs_n` low, high nibble first. A selection that ends after only one nibble has no effect.
- R2: Opcode AFh returns six nibbles: `MFR_ID` and then `DEV_ID`, 24 bits, most significant nibble first. After the sixth nibble `dq_oe` goes low for the rest of the selection.
- R3: Read nibbles change on the falling `sclk` edge. The first nibble appears on the falling edge right after the second opcode nibble is sampled. `dq_oe` is high only in a read's output phase and falls at once when `cs_n` goes high.
- R4: Opcodes 85h (volatile byte) and 65h (enhanced volatile byte) output the register high nibble, then the low nibble, and repeat for as long as `cs_n` stays low.
- R5: Opcodes 81h and 61h followed by exactly two nibbles (high first) write that byte to the volatile or enhanced volatile register when `cs_n` rises.
- R6: Opcode B1h followed by exactly four nibbles writes the non-volatile word. The first byte goes to bits 7:0 and the second byte to bits 15:8, each byte high nibble first.
- R7: A write whose data nibble count at deselect is short or too long leaves every register unchanged and starts no busy period.
- R8: After an accepted B1h, `wip` is high for exactly `NV_WAIT` rising edges with `nv_cfg` unchanged, and `nv_cfg` takes the new word as `wip` falls. A B1h received while `wip` is high is ignored.
- R9: Opcode AFh received while `array_busy` or `wip` is high is ignored, and `dq_oe` stays low.
- R10: Opcode B9h with no further nibble enters deep power-down when `cs_n` rises, and `deep_pd` goes high. B9h followed by an extra nibble does nothing.
- R11: In deep power-down every opcode other than ABh is ignored: reads drive nothing and writes change nothing. ABh with no further nibble leaves deep power-down when `cs_n` rises.
- R12: After reset `dq_oe`, `wip` and `deep_pd` are low, `nv_cfg` equals `NVCFG_RST`, and the two volatile registers equal `VCFG_RST` and `ECFG_RST`.
- R13: An unknown opcode is ignored for the rest of the selection: no output and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock, also the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| dq_in | input | 4 | Data lines as seen by the block |
| array_busy | input | 1 | Erase or program in progress |
| dq_out | output | 4 | Read nibble driven onto the data lines |
| dq_oe | output | 1 | Output enable for `dq_out`; low means tristated |
| wip | output | 1 | Non-volatile write in progress |
| deep_pd | output | 1 | Deep power-down active |
| nv_cfg | output | 16 | Committed non-volatile configuration word |

## Verification
The bench builds the block with `NV_WAIT` = 20. That keeps the busy window short enough to count every edge of it, and long enough that an identification read and a second non-volatile write both land inside it. Identification and reset values are chosen so that no two nibbles of a stream are alike: `MFR_ID` C3h, `DEV_ID` 7E49h, `VCFG_RST` A5h, `ECFG_RST` 3Ch and `NVCFG_RST` F00Fh. With those values a wrong nibble order, a swapped byte or a lost write shows up as a mismatch.

// File: rtl/qspi_resp_pkg.sv
`timescale 1ns/1ps
package qspi_resp_pkg;

    localparam int LANES     = 4;
    localparam int BYTE_NIBS = 8 / LANES;
    localparam int ID_NIBS   = 24 / LANES;
    localparam int CNT_W     = 3;

    localparam logic [7:0] OPC_ID_RD    = 8'hAF;
    localparam logic [7:0] OPC_VCFG_RD  = 8'h85;
    localparam logic [7:0] OPC_VCFG_WR  = 8'h81;
    localparam logic [7:0] OPC_ECFG_RD  = 8'h65;
    localparam logic [7:0] OPC_ECFG_WR  = 8'h61;
    localparam logic [7:0] OPC_NVCFG_WR = 8'hB1;
    localparam logic [7:0] OPC_SLEEP    = 8'hB9;
    localparam logic [7:0] OPC_WAKE     = 8'hAB;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_OPCODE,
        ST_WDATA,
        ST_RDATA,
        ST_ARMED,
        ST_IGNORE
    } xact_state_t;

    typedef enum logic [1:0] {
        SRC_ID,
        SRC_VCFG,
        SRC_ECFG
    } rd_src_t;

    typedef enum logic [1:0] {
        DST_VCFG,
        DST_ECFG,
        DST_NVCFG
    } wr_dst_t;

    typedef enum logic {
        ARM_SLEEP,
        ARM_WAKE
    } arm_t;

    typedef enum logic {
        PWR_ON,
        PWR_DEEP
    } pwr_state_t;

    typedef enum logic {
        NV_IDLE,
        NV_BUSY
    } nv_state_t;

endpackage

// File: rtl/qspi_xact_fsm.sv
`timescale 1ns/1ps
module qspi_xact_fsm
    import qspi_resp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic [LANES-1:0] dq_in,
    input  logic             deep_pd,
    input  logic             wip,
    input  logic             array_busy,
    output logic             rd_active,
    output rd_src_t          rd_src,
    output logic [CNT_W-1:0] rd_ptr,
    output logic             cmt_vcfg,
    output logic             cmt_ecfg,
    output logic             cmt_nvcfg,
    output logic             cmt_sleep,
    output logic             cmt_wake,
    output logic [15:0]      wr_data
);

    localparam logic [CNT_W-1:0] NEED_BYTE = CNT_W'(BYTE_NIBS);
    localparam logic [CNT_W-1:0] NEED_WORD = CNT_W'(2 * BYTE_NIBS);
    localparam logic [CNT_W-1:0] ID_LAST   = CNT_W'(ID_NIBS - 1);

    xact_state_t      state, state_nx, dec_state;
    rd_src_t          dec_src;
    wr_dst_t          wr_dst, dec_dst;
    arm_t             arm_kind, dec_arm;
    logic [LANES-1:0] opc_hi;
    logic [7:0]       full_opc;
    logic [15:0]      wbuf;
    logic [CNT_W-1:0] nib_cnt;
    logic [CNT_W-1:0] need;
    logic             exact;

    assign need     = (wr_dst == DST_NVCFG) ? NEED_WORD : NEED_BYTE;
    assign full_opc = {opc_hi, dq_in};

    // opcode decode, used on the second opcode nibble
    always_comb begin
        dec_state = ST_IGNORE;
        dec_src   = SRC_ID;
        dec_dst   = DST_VCFG;
        dec_arm   = ARM_SLEEP;
        if (deep_pd) begin
            if (full_opc == OPC_WAKE) begin
                dec_state = ST_ARMED;
                dec_arm   = ARM_WAKE;
            end
        end else begin
            unique case (full_opc)
                OPC_ID_RD: begin
                    if (!(array_busy || wip)) begin
                        dec_state = ST_RDATA;
                        dec_src   = SRC_ID;
                    end
                end
                OPC_VCFG_RD: begin
                    dec_state = ST_RDATA;
                    dec_src   = SRC_VCFG;
                end
                OPC_ECFG_RD: begin
                    dec_state = ST_RDATA;
                    dec_src   = SRC_ECFG;
                end
                OPC_VCFG_WR: begin
                    dec_state = ST_WDATA;
                    dec_dst   = DST_VCFG;
                end
                OPC_ECFG_WR: begin
                    dec_state = ST_WDATA;
                    dec_dst   = DST_ECFG;
                end
                OPC_NVCFG_WR: begin
                    if (!wip) begin
                        dec_state = ST_WDATA;
                        dec_dst   = DST_NVCFG;
                    end
                end
                OPC_SLEEP: begin
                    dec_state = ST_ARMED;
                    dec_arm   = ARM_SLEEP;
                end
                OPC_WAKE: begin
                    dec_state = ST_ARMED;
                    dec_arm   = ARM_WAKE;
                end
                default: dec_state = ST_IGNORE;
            endcase
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (cs_n) begin
            state_nx = ST_STANDBY;
        end else begin
            unique case (state)
                ST_STANDBY: state_nx = ST_OPCODE;
                ST_OPCODE:  state_nx = dec_state;
                ST_WDATA:   if (nib_cnt == need) state_nx = ST_IGNORE;
                ST_RDATA:   if (rd_src == SRC_ID && rd_ptr == ID_LAST) state_nx = ST_IGNORE;
                ST_ARMED:   state_nx = ST_IGNORE;
                ST_IGNORE:  state_nx = ST_IGNORE;
                default:    state_nx = ST_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STANDBY;
        else        state <= state_nx;
    end

    // transaction datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_hi   <= '0;
            wbuf     <= '0;
            nib_cnt  <= '0;
            rd_ptr   <= '0;
            rd_src   <= SRC_ID;
            wr_dst   <= DST_VCFG;
            arm_kind <= ARM_SLEEP;
        end else if (!cs_n) begin
            unique case (state)
                ST_STANDBY: opc_hi <= dq_in;
                ST_OPCODE: begin
                    rd_src   <= dec_src;
                    wr_dst   <= dec_dst;
                    arm_kind <= dec_arm;
                    nib_cnt  <= '0;
                    rd_ptr   <= '0;
                    wbuf     <= '0;
                end
                ST_WDATA: begin
                    wbuf    <= {wbuf[15-LANES:0], dq_in};
                    nib_cnt <= nib_cnt + 1'b1;
                end
                ST_RDATA: rd_ptr <= rd_ptr + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs: commit strobes on an exact boundary at deselect
    always_comb begin
        exact     = cs_n && (state == ST_WDATA) && (nib_cnt == need);
        cmt_vcfg  = exact && (wr_dst == DST_VCFG);
        cmt_ecfg  = exact && (wr_dst == DST_ECFG);
        cmt_nvcfg = exact && (wr_dst == DST_NVCFG);
        cmt_sleep = cs_n && (state == ST_ARMED) && (arm_kind == ARM_SLEEP);
        cmt_wake  = cs_n && (state == ST_ARMED) && (arm_kind == ARM_WAKE);
        rd_active = !cs_n && (state == ST_RDATA);
        wr_data   = wbuf;
    end

endmodule

// File: rtl/qspi_cfg_store.sv
`timescale 1ns/1ps
module qspi_cfg_store
    import qspi_resp_pkg::*;
#(
    parameter logic [7:0]  VCFG_RST  = 8'hFB,
    parameter logic [7:0]  ECFG_RST  = 8'hDF,
    parameter logic [15:0] NVCFG_RST = 16'hFFFF,
    parameter int          NV_WAIT   = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmt_vcfg,
    input  logic        cmt_ecfg,
    input  logic        cmt_nvcfg,
    input  logic        cmt_sleep,
    input  logic        cmt_wake,
    input  logic [15:0] wr_data,
    output logic [7:0]  vcfg,
    output logic [7:0]  ecfg,
    output logic [15:0] nvcfg,
    output logic        wip,
    output logic        deep_pd
);

    localparam int NW_W = (NV_WAIT < 2) ? 1 : $clog2(NV_WAIT);
    localparam logic [NW_W-1:0] NW_LOAD = NW_W'(NV_WAIT - 1);

    pwr_state_t      pwr, pwr_nx;
    nv_state_t       nv, nv_nx;
    logic [NW_W-1:0] nv_cnt;
    logic [15:0]     nv_hold;

    // power machine
    always_comb begin
        pwr_nx = pwr;
        unique case (pwr)
            PWR_ON:   if (cmt_sleep) pwr_nx = PWR_DEEP;
            PWR_DEEP: if (cmt_wake)  pwr_nx = PWR_ON;
            default:  pwr_nx = PWR_ON;
        endcase
    end

    // non-volatile write machine
    always_comb begin
        nv_nx = nv;
        unique case (nv)
            NV_IDLE: if (cmt_nvcfg) nv_nx = NV_BUSY;
            NV_BUSY: if (nv_cnt == '0) nv_nx = NV_IDLE;
            default: nv_nx = NV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr <= PWR_ON;
            nv  <= NV_IDLE;
        end else begin
            pwr <= pwr_nx;
            nv  <= nv_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vcfg    <= VCFG_RST;
            ecfg    <= ECFG_RST;
            nvcfg   <= NVCFG_RST;
            nv_hold <= NVCFG_RST;
            nv_cnt  <= '0;
        end else begin
            if (cmt_vcfg) vcfg <= wr_data[7:0];
            if (cmt_ecfg) ecfg <= wr_data[7:0];
            if (nv == NV_IDLE && cmt_nvcfg) begin
                nv_hold <= {wr_data[7:0], wr_data[15:8]};
                nv_cnt  <= NW_LOAD;
            end else if (nv == NV_BUSY) begin
                if (nv_cnt == '0) nvcfg  <= nv_hold;
                else              nv_cnt <= nv_cnt - 1'b1;
            end
        end
    end

    always_comb begin
        wip     = (nv == NV_BUSY);
        deep_pd = (pwr == PWR_DEEP);
    end

endmodule

// File: rtl/qspi_nib_driver.sv
`timescale 1ns/1ps
module qspi_nib_driver
    import qspi_resp_pkg::*;
#(
    parameter logic [7:0]  MFR_ID = 8'h5A,
    parameter logic [15:0] DEV_ID = 16'h3C71
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_active,
    input  rd_src_t          rd_src,
    input  logic [CNT_W-1:0] rd_ptr,
    input  logic [7:0]       vcfg,
    input  logic [7:0]       ecfg,
    output logic [LANES-1:0] dq_q,
    output logic             oe_q
);

    localparam logic [ID_NIBS*LANES-1:0] ID_WORD = {MFR_ID, DEV_ID};

    logic [LANES-1:0] id_nib;
    logic [LANES-1:0] nib_sel;
    logic [7:0]       reg_byte;

    always_comb begin
        id_nib = '0;
        for (int i = 0; i < ID_NIBS; i++) begin
            if (rd_ptr == CNT_W'(i)) id_nib = ID_WORD[(ID_NIBS-1-i)*LANES +: LANES];
        end
    end

    always_comb begin
        reg_byte = (rd_src == SRC_ECFG) ? ecfg : vcfg;
        if (rd_src == SRC_ID) nib_sel = id_nib;
        else                  nib_sel = rd_ptr[0] ? reg_byte[3:0] : reg_byte[7:4];
    end

    // launch on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_q <= '0;
            oe_q <= 1'b0;
        end else begin
            dq_q <= nib_sel;
            oe_q <= rd_active;
        end
    end

endmodule

// File: rtl/qspi_cmd_responder.sv
`timescale 1ns/1ps
module qspi_cmd_responder
    import qspi_resp_pkg::*;
#(
    parameter logic [7:0]  MFR_ID    = 8'h5A,
    parameter logic [15:0] DEV_ID    = 16'h3C71,
    parameter logic [7:0]  VCFG_RST  = 8'hFB,
    parameter logic [7:0]  ECFG_RST  = 8'hDF,
    parameter logic [15:0] NVCFG_RST = 16'hFFFF,
    parameter int          NV_WAIT   = 64
) (
    input  logic        sclk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic [3:0]  dq_in,
    input  logic        array_busy,
    output logic [3:0]  dq_out,
    output logic        dq_oe,
    output logic        wip,
    output logic        deep_pd,
    output logic [15:0] nv_cfg
);

    rd_src_t          rd_src;
    logic [CNT_W-1:0] rd_ptr;
    logic             rd_active;
    logic             cmt_vcfg, cmt_ecfg, cmt_nvcfg, cmt_sleep, cmt_wake;
    logic [15:0]      wr_data;
    logic [7:0]       vcfg_w, ecfg_w;
    logic             oe_q;

    qspi_xact_fsm u_fsm (
        .clk        (sclk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .dq_in      (dq_in),
        .deep_pd    (deep_pd),
        .wip        (wip),
        .array_busy (array_busy),
        .rd_active  (rd_active),
        .rd_src     (rd_src),
        .rd_ptr     (rd_ptr),
        .cmt_vcfg   (cmt_vcfg),
        .cmt_ecfg   (cmt_ecfg),
        .cmt_nvcfg  (cmt_nvcfg),
        .cmt_sleep  (cmt_sleep),
        .cmt_wake   (cmt_wake),
        .wr_data    (wr_data)
    );

    qspi_cfg_store #(
        .VCFG_RST  (VCFG_RST),
        .ECFG_RST  (ECFG_RST),
        .NVCFG_RST (NVCFG_RST),
        .NV_WAIT   (NV_WAIT)
    ) u_store (
        .clk       (sclk),
        .rst_n     (rst_n),
        .cmt_vcfg  (cmt_vcfg),
        .cmt_ecfg  (cmt_ecfg),
        .cmt_nvcfg (cmt_nvcfg),
        .cmt_sleep (cmt_sleep),
        .cmt_wake  (cmt_wake),
        .wr_data   (wr_data),
        .vcfg      (vcfg_w),
        .ecfg      (ecfg_w),
        .nvcfg     (nv_cfg),
        .wip       (wip),
        .deep_pd   (deep_pd)
    );

    qspi_nib_driver #(
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_drv (
        .clk       (sclk),
        .rst_n     (rst_n),
        .rd_active (rd_active),
        .rd_src    (rd_src),
        .rd_ptr    (rd_ptr),
        .vcfg      (vcfg_w),
        .ecfg      (ecfg_w),
        .dq_q      (dq_out),
        .oe_q      (oe_q)
    );

    assign dq_oe = oe_q & ~cs_n;

endmodule

// File: rtl/qspi_cmd_responder_chk.sv
`timescale 1ns/1ps
module qspi_cmd_responder_chk (
    input logic        sclk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        dq_oe,
    input logic        wip,
    input logic        deep_pd,
    input logic [15:0] nv_cfg,
    input logic [7:0]  vcfg_q,
    input logic [7:0]  ecfg_q
);

    // R8: the committed word only moves at the end of a busy period
    p_nv_hold_r8: assert property (@(posedge sclk) disable iff (!rst_n)
        !$past(wip) |-> $stable(nv_cfg));

    // R11: nothing is driven while powered down
    p_quiet_deep_r11: assert property (@(posedge sclk) disable iff (!rst_n)
        deep_pd |-> !dq_oe);

    // R10: power-down entry only at deselect
    p_sleep_deselect_r10: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(deep_pd) |-> $past(cs_n));

    // R11: power-down release only at deselect
    p_wake_deselect_r11: assert property (@(posedge sclk) disable iff (!rst_n)
        $fell(deep_pd) |-> $past(cs_n));

    // R5: volatile bytes change only at deselect
    p_vcfg_deselect_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        !$stable(vcfg_q) |-> $past(cs_n));

    p_ecfg_deselect_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        !$stable(ecfg_q) |-> $past(cs_n));

endmodule

bind qspi_cmd_responder qspi_cmd_responder_chk u_chk (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .dq_oe   (dq_oe),
    .wip     (wip),
    .deep_pd (deep_pd),
    .nv_cfg  (nv_cfg),
    .vcfg_q  (vcfg_w),
    .ecfg_q  (ecfg_w)
);

// File: tb/qspi_cmd_responder_bench.sv
`timescale 1ns/1ps
module qspi_cmd_responder_bench;

    localparam int NVW = 20;

    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [3:0]  dq_in = '0;
    logic        array_busy = 1'b0;
    logic [3:0]  dq_out;
    logic        dq_oe;
    logic        wip;
    logic        deep_pd;
    logic [15:0] nv_cfg;

    int checks = 0;
    int errors = 0;

    qspi_cmd_responder #(
        .MFR_ID    (8'hC3),
        .DEV_ID    (16'h7E49),
        .VCFG_RST  (8'hA5),
        .ECFG_RST  (8'h3C),
        .NVCFG_RST (16'hF00F),
        .NV_WAIT   (NVW)
    ) u_qspi_cmd_responder (
        .sclk       (sclk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .dq_in      (dq_in),
        .array_busy (array_busy),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe),
        .wip        (wip),
        .deep_pd    (deep_pd),
        .nv_cfg     (nv_cfg)
    );

    always #2 sclk = ~sclk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic nib(input logic [3:0] v);
        @(negedge sclk);
        cs_n  = 1'b0;
        dq_in = v;
    endtask

    task automatic opcode(input logic [7:0] op);
        nib(op[7:4]);
        nib(op[3:0]);
    endtask

    task automatic end_sel();
        @(negedge sclk);
        cs_n  = 1'b1;
        dq_in = '0;
        repeat (3) @(negedge sclk);
    endtask

    // one read nibble, sampled after the falling edge that launched it
    task automatic rd_nib(output logic [3:0] v);
        @(negedge sclk);
        #1;
        v = dq_oe ? dq_out : 4'hx;
    endtask

    task automatic read_reg(input logic [7:0] op, output logic [7:0] val);
        logic [3:0] hi, lo;
        opcode(op);
        rd_nib(hi);
        rd_nib(lo);
        end_sel();
        val = {hi, lo};
    endtask

    task automatic write_nibs(input logic [7:0] op, input int n, input logic [15:0] d);
        opcode(op);
        for (int i = 0; i < n; i++) nib(d[15-4*i -: 4]);
        end_sel();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R12", "dq_oe after reset", 32'(dq_oe), 32'd0);
        chk("R12", "wip after reset", 32'(wip), 32'd0);
        chk("R12", "deep_pd after reset", 32'(deep_pd), 32'd0);
        chk("R12", "nv_cfg after reset", 32'(nv_cfg), 32'hF00F);
        read_reg(8'h85, v);
        chk("R12", "volatile reset value", 32'(v), 32'hA5);
        read_reg(8'h65, v);
        chk("R12", "enhanced reset value", 32'(v), 32'h3C);
    endtask

    task automatic t_id_read();
        logic [3:0]  v;
        logic [23:0] exp = 24'hC37E49;
        opcode(8'hAF);
        for (int i = 0; i < 6; i++) begin
            rd_nib(v);
            chk("R2", "id nibble", 32'(v), 32'(exp[23-4*i -: 4]));
        end
        @(negedge sclk); #1;
        chk("R2", "oe after sixth id nibble", 32'(dq_oe), 32'd0);
        end_sel();
    endtask

    task automatic t_reg_repeat();
        logic [3:0] v;
        opcode(8'h85);
        for (int i = 0; i < 6; i++) begin
            rd_nib(v);
            chk("R4", "repeating volatile nibble", 32'(v), (i % 2 == 0) ? 32'hA : 32'h5);
        end
        @(posedge sclk); #1;
        chk("R3", "nibble holds across rising edge", 32'(dq_out), 32'h5);
        @(negedge sclk);
        cs_n = 1'b1;
        #1;
        chk("R3", "oe falls with deselect", 32'(dq_oe), 32'd0);
        repeat (3) @(negedge sclk);
    endtask

    task automatic t_vol_write();
        logic [7:0] v;
        write_nibs(8'h81, 2, 16'h6E00);
        read_reg(8'h85, v);
        chk("R5", "volatile write", 32'(v), 32'h6E);
        write_nibs(8'h61, 2, 16'h9100);
        read_reg(8'h65, v);
        chk("R5", "enhanced write", 32'(v), 32'h91);
        read_reg(8'h85, v);
        chk("R5", "volatile untouched by enhanced write", 32'(v), 32'h6E);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        write_nibs(8'h81, 1, 16'h7000);
        read_reg(8'h85, v);
        chk("R7", "short write ignored", 32'(v), 32'h6E);
        write_nibs(8'h81, 3, 16'h1230);
        read_reg(8'h85, v);
        chk("R7", "long write ignored", 32'(v), 32'h6E);
        nib(4'h8);
        end_sel();
        read_reg(8'h65, v);
        chk("R1", "half opcode ignored, next read fine", 32'(v), 32'h91);
        write_nibs(8'hB1, 2, 16'h5500);
        chk("R7", "short nv write starts no busy", 32'(wip), 32'd0);
        chk("R7", "short nv write keeps word", 32'(nv_cfg), 32'hF00F);
    endtask

    task automatic t_unknown();
        logic [7:0] v;
        opcode(8'h3D);
        nib(4'h4);
        nib(4'h4);
        #1;
        chk("R13", "unknown opcode drives nothing", 32'(dq_oe), 32'd0);
        end_sel();
        read_reg(8'h85, v);
        chk("R13", "unknown opcode changes nothing", 32'(v), 32'h6E);
    endtask

    task automatic t_nv_write();
        int busy_cnt = 0;
        opcode(8'hB1);
        nib(4'h2); nib(4'hD); nib(4'h8); nib(4'h4);
        @(negedge sclk);
        cs_n = 1'b1;
        for (int k = 1; k <= NVW + 1; k++) begin
            @(negedge sclk); #1;
            if (wip) begin
                busy_cnt++;
                if (nv_cfg !== 16'hF00F) chk("R8", "word held while busy", 32'(nv_cfg), 32'hF00F);
            end
        end
        chk("R8", "busy length", 32'(busy_cnt), 32'(NVW));
        chk("R6", "nv byte order", 32'(nv_cfg), 32'h842D);
        chk("R8", "busy cleared", 32'(wip), 32'd0);
    endtask

    task automatic t_nv_busy();
        logic [3:0] v;
        write_nibs(8'hB1, 4, 16'h1234);
        chk("R8", "busy after nv write", 32'(wip), 32'd1);
        opcode(8'hAF);
        rd_nib(v);
        chk("R9", "id ignored while write busy", 32'(dq_oe), 32'd0);
        end_sel();
        write_nibs(8'hB1, 4, 16'h5678);
        repeat (NVW + 4) @(negedge sclk);
        chk("R8", "nv write during busy ignored", 32'(nv_cfg), 32'h3412);
        array_busy = 1'b1;
        opcode(8'hAF);
        rd_nib(v);
        chk("R9", "id ignored while array busy", 32'(dq_oe), 32'd0);
        end_sel();
        array_busy = 1'b0;
        opcode(8'hAF);
        rd_nib(v);
        chk("R9", "id served when idle", 32'(v), 32'hC);
        end_sel();
    endtask

    task automatic t_deep();
        logic [7:0] v;
        logic [3:0] n;
        write_nibs(8'hB9, 1, 16'h0000);
        chk("R10", "sleep with extra nibble ignored", 32'(deep_pd), 32'd0);
        write_nibs(8'hB9, 0, 16'h0000);
        chk("R10", "sleep entered", 32'(deep_pd), 32'd1);
        opcode(8'h85);
        rd_nib(n);
        chk("R11", "read ignored in deep power-down", 32'(dq_oe), 32'd0);
        end_sel();
        write_nibs(8'h81, 2, 16'h2200);
        write_nibs(8'hAB, 1, 16'h0000);
        chk("R11", "wake with extra nibble ignored", 32'(deep_pd), 32'd1);
        write_nibs(8'hAB, 0, 16'h0000);
        chk("R11", "wake released", 32'(deep_pd), 32'd0);
        read_reg(8'h85, v);
        chk("R11", "write in deep power-down ignored", 32'(v), 32'h6E);
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge sclk);
        rst_n = 1'b1;
        repeat (2) @(negedge sclk);
        #1;
        t_reset();
        t_id_read();
        t_reg_repeat();
        t_vol_write();
        t_abort();
        t_unknown();
        t_nv_write();
        t_nv_busy();
        t_deep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule